// File: doc/BRIEF.md
# Byte-Parallel Transport-Stream Bit-Error Checker

This block watches a byte-wide transport stream that repeats one fixed test packet, and measures how many bits arrive corrupted. It takes one byte on every cycle where the enable is high. It first hunts for the sync value 0x47. It stores the packet that starts there in a reference memory, then proves that memory correct by requiring the next two packets to match it bit for bit. From that point every byte is XORed with the stored byte at the same packet offset. A bit counter gains eight per byte, and an error counter gains the number of set bits in the XOR.

Alignment is watched at offset zero of each packet. Three missing sync bytes in a row drop the lock, add one to a resync event counter and send the block back to hunting. The receiver's clock recovery can add or drop bytes, and this is how the block follows such a slip. Software reads the two counters and forms the error ratio itself. A synchronous clear input zeroes all three counters.

Top module: `ts_err_checker`

## Requirements
- R1: After reset `locked` is 0 and `bitCount`, `errCount` and `resyncCount` are all 0.
- R2: While hunting, bytes other than 0x47 are ignored. A 0x47 byte starts a capture whose packet length is `LEN_SHORT` (188 by default) when `lenSel` is 0 and `LEN_LONG` (204 by default) when `lenSel` is 1. `lenSel` is sampled only on that starting byte, so changing it later has no effect until the next capture.
- R3: `locked` rises in the cycle after the last byte of the second packet that follows the captured one, provided both packets equal the reference exactly. No count changes before that.
- R4: A byte that differs from the reference during verification abandons the reference, and hunting restarts with the next byte. The rest of that packet is ignored unless it contains 0x47.
- R5: While locked, each accepted byte adds 8 to `bitCount` and adds to `errCount` the number of 1 bits in (byte XOR reference byte at the same offset). While not locked, neither counter changes.
- R6: While locked, a byte other than 0x47 at offset 0 in one or two consecutive packets keeps the lock. A correct sync byte ends the run of misses.
- R7: The third consecutive missing sync byte is still counted. `locked` falls in the next cycle, `resyncCount` rises by one (saturating) and hunting restarts.
- R8: `clearCnt` high in a cycle makes all three counters 0 in the next cycle, even when a byte is counted in that same cycle. `clearCnt` does not change `locked`.
- R9: `bitCount` and `errCount` saturate at all ones (2^`CNT_W`-1) instead of wrapping.
- R10: A cycle with `byteEn` low advances nothing: no offset, state or count change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteEn | input | 1 | Qualifies `dataIn` for this cycle |
| dataIn | input | 8 | Received stream byte |
| lenSel | input | 1 | Packet length select: 0 short, 1 long |
| clearCnt | input | 1 | Synchronous clear of all counters |
| locked | output | 1 | Reference verified and checking active |
| bitCount | output | CNT_W | Saturating count of bits checked |
| errCount | output | CNT_W | Saturating count of bit errors |
| resyncCount | output | RES_W | Saturating count of lock losses |

## Verification
Two pairs of events can land in the same cycle. A counter clear can meet a counted byte. The third missing sync byte also ends the lock in the cycle where it is counted. The bench raises `clearCnt` on a mid-packet byte while locked. It expects the counters to be zero on that edge and then to grow only by the bytes that follow. It also sends three sync-corrupted packets in a row. It then checks that the counters include the corrupted sync byte of the last one but none of the bytes after it, and that `resyncCount` rose exactly once.

// File: rtl/ts_chk_pkg.sv
package ts_chk_pkg;
  localparam logic [7:0] SYNC_BYTE = 8'h47;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CAPTURE = 2'd1,
    ST_VERIFY  = 2'd2,
    ST_LOCKED  = 2'd3
  } chkState_t;

  typedef struct packed {
    logic wrRef;      // store current byte into reference
    logic countEn;    // accumulate bits and errors for current byte
    logic resyncInc;  // lock lost on this byte
    logic clr;        // clear counters
  } chkStrobe_t;
endpackage

// File: rtl/ts_chk_ctrl.sv
module ts_chk_ctrl
  import ts_chk_pkg::*;
#(
  parameter int LEN_SHORT   = 188,
  parameter int LEN_LONG    = 204,
  parameter int VERIFY_PKTS = 2,
  parameter int MISS_LIMIT  = 3,
  localparam int MAX_LEN    = (LEN_LONG > LEN_SHORT) ? LEN_LONG : LEN_SHORT,
  localparam int OFF_W      = $clog2(MAX_LEN),
  localparam int PASS_W     = $clog2(VERIFY_PKTS + 1),
  localparam int MISS_W     = $clog2(MISS_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteEn,
  input  logic [7:0]       dataIn,
  input  logic             lenSel,
  input  logic             clearCnt,
  input  logic             mismatch,
  output chkStrobe_t       strobe,
  output logic [OFF_W-1:0] refIdx,
  output logic             locked
);
  chkState_t         state;
  logic [OFF_W-1:0]  offset;
  logic              lenLong;
  logic [PASS_W-1:0] passCnt;
  logic [MISS_W-1:0] missCnt;
  logic [OFF_W-1:0]  lastIdx;
  logic              isSync;
  logic              atLast;
  logic              missFinal;

  assign lastIdx   = lenLong ? OFF_W'(LEN_LONG - 1) : OFF_W'(LEN_SHORT - 1);
  assign isSync    = (dataIn == SYNC_BYTE);
  assign atLast    = (offset == lastIdx);
  assign missFinal = (offset == '0) && !isSync && (missCnt == MISS_W'(MISS_LIMIT - 1));
  assign locked    = (state == ST_LOCKED);

  always_comb begin
    strobe     = '0;
    strobe.clr = clearCnt;
    refIdx     = offset;
    unique case (state)
      ST_HUNT: begin
        refIdx       = '0;
        strobe.wrRef = byteEn && isSync;
      end
      ST_CAPTURE: strobe.wrRef = byteEn;
      ST_VERIFY:  ;
      ST_LOCKED: begin
        strobe.countEn   = byteEn;
        strobe.resyncInc = byteEn && missFinal;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      offset  <= '0;
      lenLong <= 1'b0;
      passCnt <= '0;
      missCnt <= '0;
    end else if (byteEn) begin
      unique case (state)
        ST_HUNT: begin
          if (isSync) begin
            lenLong <= lenSel;
            offset  <= OFF_W'(1);
            state   <= ST_CAPTURE;
          end
        end
        ST_CAPTURE: begin
          if (atLast) begin
            offset  <= '0;
            passCnt <= '0;
            state   <= ST_VERIFY;
          end else begin
            offset <= offset + OFF_W'(1);
          end
        end
        ST_VERIFY: begin
          if (mismatch) begin
            offset <= '0;
            state  <= ST_HUNT;
          end else if (atLast) begin
            offset <= '0;
            if (passCnt == PASS_W'(VERIFY_PKTS - 1)) begin
              missCnt <= '0;
              state   <= ST_LOCKED;
            end else begin
              passCnt <= passCnt + PASS_W'(1);
            end
          end else begin
            offset <= offset + OFF_W'(1);
          end
        end
        ST_LOCKED: begin
          offset <= atLast ? '0 : offset + OFF_W'(1);
          if (offset == '0) begin
            if (isSync) begin
              missCnt <= '0;
            end else if (missFinal) begin
              offset <= '0;
              state  <= ST_HUNT;
            end else begin
              missCnt <= missCnt + MISS_W'(1);
            end
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/ts_chk_dp.sv
module ts_chk_dp
  import ts_chk_pkg::*;
#(
  parameter int MAX_LEN = 204,
  parameter int CNT_W   = 48,
  parameter int RES_W   = 16,
  localparam int OFF_W  = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  chkStrobe_t       strobe,
  input  logic [OFF_W-1:0] refIdx,
  input  logic [7:0]       dataIn,
  output logic             mismatch,
  output logic [CNT_W-1:0] bitCount,
  output logic [CNT_W-1:0] errCount,
  output logic [RES_W-1:0] resyncCount
);
  logic [7:0]       refMem [MAX_LEN];
  logic [7:0]       diff;
  logic [3:0]       diffOnes;
  logic [CNT_W:0]   bitSum;
  logic [CNT_W:0]   errSum;
  logic [RES_W:0]   resSum;

  function automatic logic [3:0] onesOf(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + 4'(v[i]);
    return n;
  endfunction

  assign diff     = dataIn ^ refMem[refIdx];
  assign mismatch = |diff;
  assign diffOnes = onesOf(diff);
  assign bitSum   = {1'b0, bitCount} + (CNT_W + 1)'(8);
  assign errSum   = {1'b0, errCount} + (CNT_W + 1)'(diffOnes);
  assign resSum   = {1'b0, resyncCount} + (RES_W + 1)'(1);

  always_ff @(posedge clk) begin
    if (strobe.wrRef) refMem[refIdx] <= dataIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clr) begin
      bitCount    <= '0;
      errCount    <= '0;
      resyncCount <= '0;
    end else begin
      if (strobe.countEn) begin
        bitCount <= bitSum[CNT_W] ? '1 : bitSum[CNT_W-1:0];
        errCount <= errSum[CNT_W] ? '1 : errSum[CNT_W-1:0];
      end
      if (strobe.resyncInc)
        resyncCount <= resSum[RES_W] ? '1 : resSum[RES_W-1:0];
    end
  end
endmodule

// File: rtl/ts_err_checker.sv
module ts_err_checker
  import ts_chk_pkg::*;
#(
  parameter int LEN_SHORT   = 188,
  parameter int LEN_LONG    = 204,
  parameter int VERIFY_PKTS = 2,
  parameter int MISS_LIMIT  = 3,
  parameter int CNT_W       = 48,
  parameter int RES_W       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteEn,
  input  logic [7:0]       dataIn,
  input  logic             lenSel,
  input  logic             clearCnt,
  output logic             locked,
  output logic [CNT_W-1:0] bitCount,
  output logic [CNT_W-1:0] errCount,
  output logic [RES_W-1:0] resyncCount
);
  localparam int MAX_LEN = (LEN_LONG > LEN_SHORT) ? LEN_LONG : LEN_SHORT;
  localparam int OFF_W   = $clog2(MAX_LEN);

  chkStrobe_t       strobe;
  logic [OFF_W-1:0] refIdx;
  logic             mismatch;

  ts_chk_ctrl #(
    .LEN_SHORT(LEN_SHORT), .LEN_LONG(LEN_LONG),
    .VERIFY_PKTS(VERIFY_PKTS), .MISS_LIMIT(MISS_LIMIT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .byteEn(byteEn), .dataIn(dataIn),
    .lenSel(lenSel), .clearCnt(clearCnt), .mismatch(mismatch),
    .strobe(strobe), .refIdx(refIdx), .locked(locked)
  );

  ts_chk_dp #(
    .MAX_LEN(MAX_LEN), .CNT_W(CNT_W), .RES_W(RES_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .refIdx(refIdx),
    .dataIn(dataIn), .mismatch(mismatch), .bitCount(bitCount),
    .errCount(errCount), .resyncCount(resyncCount)
  );
endmodule

// File: rtl/ts_err_checker_sva.sv
module ts_err_checker_sva #(
  parameter int CNT_W = 48,
  parameter int RES_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             byteEn,
  input logic             clearCnt,
  input logic             locked,
  input logic [CNT_W-1:0] bitCount,
  input logic [CNT_W-1:0] errCount,
  input logic [RES_W-1:0] resyncCount
);
  localparam logic [CNT_W-1:0] STEP_LIMIT = {CNT_W{1'b1}} - CNT_W'(8);

  assert_bit_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (locked && byteEn && !clearCnt && bitCount <= STEP_LIMIT)
      |=> bitCount == $past(bitCount) + CNT_W'(8));

  assert_err_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (locked && byteEn && !clearCnt && errCount <= STEP_LIMIT)
      |=> (errCount - $past(errCount)) <= CNT_W'(8));

  assert_no_count_unlocked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && !clearCnt) |=> ($stable(bitCount) && $stable(errCount)));

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!byteEn && !clearCnt) |=> ($stable(bitCount) && $stable(errCount)
                                && $stable(resyncCount) && $stable(locked)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    clearCnt |=> (bitCount == '0 && errCount == '0 && resyncCount == '0));

  assert_resync_on_loss_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(locked) && !$past(clearCnt))
      |-> (resyncCount == $past(resyncCount) + RES_W'(1) || (&$past(resyncCount))));

  assert_lock_on_byte_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(byteEn));

  always_ff @(posedge clk) begin
    if (rstN) begin
      assert_err_not_above_bits_R5: assert (errCount <= bitCount);
    end
  end
endmodule

bind ts_err_checker ts_err_checker_sva #(.CNT_W(CNT_W), .RES_W(RES_W)) uSva (
  .clk(clk), .rstN(rstN), .byteEn(byteEn), .clearCnt(clearCnt),
  .locked(locked), .bitCount(bitCount), .errCount(errCount),
  .resyncCount(resyncCount)
);

// File: tb/sim_ts_err_checker.sv
module sim_ts_err_checker;
  localparam int LS    = 12;
  localparam int LL    = 16;
  localparam int CNT_W = 10;
  localparam int RES_W = 4;
  localparam longint CMAX = (64'd1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             byteEn = 1'b0;
  logic [7:0]       dataIn = '0;
  logic             lenSel = 1'b0;
  logic             clearCnt = 1'b0;
  logic             locked;
  logic [CNT_W-1:0] bitCount;
  logic [CNT_W-1:0] errCount;
  logic [RES_W-1:0] resyncCount;

  int     vectors = 0;
  int     fails = 0;
  longint expBits = 0;
  longint expErr = 0;
  longint expRes = 0;
  longint cycles = 0;

  ts_err_checker #(
    .LEN_SHORT(LS), .LEN_LONG(LL), .VERIFY_PKTS(2), .MISS_LIMIT(3),
    .CNT_W(CNT_W), .RES_W(RES_W)
  ) u0 (
    .clk(clk), .rstN(rstN), .byteEn(byteEn), .dataIn(dataIn),
    .lenSel(lenSel), .clearCnt(clearCnt), .locked(locked),
    .bitCount(bitCount), .errCount(errCount), .resyncCount(resyncCount)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  function automatic logic [7:0] pktByte(input int i);
    return (i == 0) ? 8'h47 : 8'((i * 29 + 3) & 255);
  endfunction

  function automatic longint satAdd(input longint a, input longint b);
    return (a + b > CMAX) ? CMAX : a + b;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    vectors = vectors + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req, input logic expLock);
    chk({req, " locked"}, longint'(locked), longint'(expLock));
    chk({req, " bitCount"}, longint'(bitCount), expBits);
    chk({req, " errCount"}, longint'(errCount), expErr);
    chk({req, " resyncCount"}, longint'(resyncCount), expRes);
  endtask

  // Stop driving bytes; at this negedge all edges so far have settled.
  task automatic settle();
    @(negedge clk);
    byteEn   = 1'b0;
    clearCnt = 1'b0;
  endtask

  // Sends one packet. Bytes with index below cntUpTo are expected to be counted.
  // errIdx selects one corrupted byte (-1: none); invPay flips all payload bits.
  // clrIdx raises clearCnt on that byte (-1: never). A gap cycle precedes byte 5.
  task automatic sendPkt(input int len, input int errIdx, input logic [7:0] errMask,
                         input bit invPay, input int cntUpTo, input int clrIdx);
    for (int i = 0; i < len; i++) begin
      logic [7:0] m;
      m = (i == errIdx) ? errMask : 8'h00;
      if (invPay && i != 0) m = m ^ 8'hFF;
      if (i == 5) begin
        @(negedge clk);
        byteEn   = 1'b0;
        clearCnt = 1'b0;
      end
      @(negedge clk);
      byteEn   = 1'b1;
      dataIn   = pktByte(i) ^ m;
      clearCnt = (i == clrIdx);
      if (i == clrIdx) begin
        expBits = 0;
        expErr  = 0;
        expRes  = 0;
      end else if (i < cntUpTo) begin
        expBits = satAdd(expBits, 8);
        expErr  = satAdd(expErr, longint'($countones(m)));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 reset", 1'b0);

    // R2: junk bytes before any sync are ignored
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      byteEn = 1'b1;
      dataIn = 8'(j);
    end
    settle();
    checkAll("R2 junk ignored", 1'b0);

    // R3: capture plus two verified packets
    sendPkt(LS, -1, 8'h00, 1'b0, 0, -1);
    sendPkt(LS, -1, 8'h00, 1'b0, 0, -1);
    settle();
    checkAll("R3 one verified packet not locked", 1'b0);
    sendPkt(LS, -1, 8'h00, 1'b0, 0, -1);
    settle();
    checkAll("R3 locked after second verified packet", 1'b1);

    // R5: error counting by population count
    sendPkt(LS, 4, 8'h81, 1'b0, LS, -1);
    settle();
    checkAll("R5 two-bit error", 1'b1);
    sendPkt(LS, LS - 1, 8'hFF, 1'b0, LS, -1);
    settle();
    checkAll("R5 eight-bit error at last offset", 1'b1);

    // R10: idle cycles change nothing
    repeat (6) @(negedge clk);
    checkAll("R10 idle", 1'b1);

    // R6: miss, good, miss, miss keeps lock
    sendPkt(LS, 0, 8'h01, 1'b0, LS, -1);
    sendPkt(LS, -1, 8'h00, 1'b0, LS, -1);
    sendPkt(LS, 0, 8'h01, 1'b0, LS, -1);
    sendPkt(LS, 0, 8'h10, 1'b0, LS, -1);
    settle();
    checkAll("R6 two misses keep lock", 1'b1);

    // R7: third consecutive miss: only the sync byte is counted
    sendPkt(LS, 0, 8'h02, 1'b0, 1, -1);
    expRes = expRes + 1;
    settle();
    checkAll("R7 third miss drops lock", 1'b0);

    // R4: verification failure causes recapture
    sendPkt(LS, -1, 8'h00, 1'b0, 0, -1);
    sendPkt(LS, 6, 8'h04, 1'b0, 0, -1);
    sendPkt(LS, -1, 8'h00, 1'b0, 0, -1);
    sendPkt(LS, -1, 8'h00, 1'b0, 0, -1);
    settle();
    checkAll("R4 recapture not yet locked", 1'b0);
    sendPkt(LS, -1, 8'h00, 1'b0, 0, -1);
    settle();
    checkAll("R4 locked after recapture", 1'b1);

    // R8: clear on the same cycle as a counted byte
    sendPkt(LS, 9, 8'h07, 1'b0, LS, 3);
    settle();
    checkAll("R8 clear wins over count", 1'b1);

    // R2: long packets; lose lock first
    sendPkt(LS, 0, 8'h01, 1'b0, LS, -1);
    sendPkt(LS, 0, 8'h01, 1'b0, LS, -1);
    sendPkt(LS, 0, 8'h01, 1'b0, 1, -1);
    expRes = expRes + 1;
    settle();
    checkAll("R7 second loss", 1'b0);
    lenSel = 1'b1;
    sendPkt(LL, -1, 8'h00, 1'b0, 0, -1);
    lenSel = 1'b0;
    sendPkt(LL, -1, 8'h00, 1'b0, 0, -1);
    sendPkt(LL, -1, 8'h00, 1'b0, 0, -1);
    settle();
    checkAll("R2 long length locked", 1'b1);
    sendPkt(LL, LL - 1, 8'h3C, 1'b0, LL, -1);
    settle();
    checkAll("R2 long length counted, lenSel change ignored", 1'b1);

    // R9: saturation with inverted payload
    @(negedge clk);
    clearCnt = 1'b1;
    expBits = 0;
    expErr  = 0;
    expRes  = 0;
    settle();
    checkAll("R8 clear while idle", 1'b1);
    for (int p = 0; p < 11; p++) begin
      sendPkt(LL, -1, 8'h00, 1'b1, LL, -1);
      settle();
      checkAll("R9 saturation sweep", 1'b1);
    end
    chk("R9 bit counter saturated", longint'(bitCount), CMAX);
    chk("R9 error counter saturated", longint'(errCount), CMAX);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule